// File: doc/BRIEF.md
# Permutation Benchmark Checksum Controller

This block runs a repeated-permutation benchmark entirely in hardware. After a start pulse it latches its configuration and walks a run index upward from zero until it reaches the programmed run count. For each index it first decides whether that run is active. A run is active when the element count is strictly greater than the index taken modulo the frequency value.

For an active run the block loads a 25-lane, 64-bit state, with each lane set to its own lane number plus the run index. It then hands that state to an external permutation core once for every programmed round. Each time it waits for the core's result before it issues the next round. At the end of the run it adds the 25 lanes together and folds that sum into a running checksum with XOR.

The permutation core is reached through a request/ready handshake that carries the 1600-bit state out to the core. The result comes back on a done strobe with its own 1600-bit bus. The host sees a busy flag, a one-cycle done pulse and the 64-bit checksum.

Top module: `perm_bench_ctrl`

## Requirements
- R1: A run index r is active only when elem_count_i > (r mod freq_i), using unsigned 32-bit arithmetic. Inactive indices issue no permutation request and leave the checksum unchanged.
- R2: A freq_i value of zero behaves exactly like a freq_i value of one.
- R3: At the start of an active run, lane i is loaded with i + r, computed as a 64-bit value. Lane i occupies bits [64*i+63 : 64*i] of the state bus.
- R4: An active run issues exactly rounds_i permutation requests. A new request is raised only after the core's done strobe has returned the previous result. If rounds_i is zero, the seed state is folded directly.
- R5: After the last round of a run, the 25 lanes are summed modulo 2^64 and the sum is XORed into checksum_o. The checksum does not change while a request is pending.
- R6: A start_i seen while idle clears checksum_o to zero and latches all four configuration inputs. A start_i seen while busy_o is high, including the done cycle, has no effect.
- R7: done_o is high for exactly one cycle, after the last run index has been evaluated. busy_o is high from the cycle after an accepted start through the done cycle, and low after it. A run count of zero finishes with a checksum of zero.
- R8: While perm_req_o is high and perm_ready_i is low, perm_req_o stays high and perm_state_o stays unchanged.
- R9: After reset, busy_o, done_o and perm_req_o are low and checksum_o is zero.

Each requirement can be tested at the ports. The zero-rounds behaviour in R4 and the zero-frequency behaviour in R2 are design choices made to keep every input value defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a benchmark (accepted only when idle) |
| run_count_i | input | 32 | Number of run indices to evaluate |
| rounds_i | input | 32 | Permutations applied per active run |
| elem_count_i | input | 32 | Element count used in the run gate |
| freq_i | input | 32 | Modulus used in the run gate (0 treated as 1) |
| busy_o | output | 1 | Benchmark in progress |
| done_o | output | 1 | One-cycle completion pulse |
| checksum_o | output | 64 | Accumulated XOR of per-run lane sums |
| perm_req_o | output | 1 | Permutation request valid |
| perm_ready_i | input | 1 | Core accepts the request |
| perm_state_o | output | 1600 | State sent to the core |
| perm_done_i | input | 1 | Core result valid strobe |
| perm_state_i | input | 1600 | State returned by the core |

## Verification
The two events most likely to collide are the done pulse that closes a benchmark and a fresh start request. Both are decided in the same controller state transition.

The bench raises start_i in exactly the cycle where done_o is high. It then checks that busy_o drops, that no request appears, and that checksum_o keeps the finished value. A second scenario pulses start_i in the middle of a run while the core is stalling the handshake. That result must match the value computed independently from R1 to R5, and the count of accepted requests must match the count R4 predicts.

// File: rtl/pbc_pkg.sv
// Package: shared types for the permutation benchmark controller.
// Assumes: a single controller FSM; the encoding is internal only.
package pbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_ISSUE,
        ST_WAIT,
        ST_FOLD,
        ST_FINISH
    } ctl_state_e;
endpackage

// File: rtl/pbc_run_gate.sv
// Module: pbc_run_gate
// Decides whether a run index is active: the element count must be
// strictly above the index modulo the frequency.
// Assumes: a frequency of zero is replaced by one so the modulo stays defined.
module pbc_run_gate #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] run_idx_i,
    input  logic [CNT_W-1:0] elem_cnt_i,
    input  logic [CNT_W-1:0] freq_i,
    output logic             active_o
);
    logic [CNT_W-1:0] divisor;
    logic [CNT_W-1:0] remainder;

    // Guard the divisor, take the remainder, compare against the element count.
    always_comb begin
        divisor   = (freq_i == '0) ? CNT_W'(1) : freq_i;
        remainder = run_idx_i % divisor;
        active_o  = elem_cnt_i > remainder;
    end
endmodule

// File: rtl/pbc_lane_seed.sv
// Module: pbc_lane_seed
// Builds the starting state of a run: lane g holds g plus the run index.
// Assumes: lane g sits at bits [g*LANE_W +: LANE_W]; the index is zero-extended.
module pbc_lane_seed #(
    parameter int LANES  = 25,
    parameter int LANE_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic [CNT_W-1:0]        run_idx_i,
    output logic [LANES*LANE_W-1:0] seed_o
);
    localparam int TOTAL_W = LANES * LANE_W;

    logic [LANE_W-1:0] idx_ext;

    // Widen the run index to one lane.
    assign idx_ext = LANE_W'(run_idx_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One adder per lane: lane number plus run index.
        assign seed_o[g*LANE_W +: LANE_W] = LANE_W'(g) + idx_ext;
    end

    if (TOTAL_W < LANE_W) begin : g_bad_cfg
        // Never true for legal parameters; documents the expected relation.
        initial $display("pbc_lane_seed: LANES must be at least one");
    end
endmodule

// File: rtl/pbc_lane_fold.sv
// Module: pbc_lane_fold
// Adds all lanes of a state together, wrapping modulo 2^LANE_W.
// Assumes: purely combinational; the caller registers the result.
module pbc_lane_fold #(
    parameter int LANES  = 25,
    parameter int LANE_W = 64
) (
    input  logic [LANES*LANE_W-1:0] state_i,
    output logic [LANE_W-1:0]       sum_o
);
    // Walk the lanes and accumulate a wrapping sum.
    always_comb begin
        sum_o = '0;
        for (int k = 0; k < LANES; k++) begin
            sum_o = sum_o + state_i[k*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/perm_bench_ctrl.sv
// Module: perm_bench_ctrl (top)
// Sequences the benchmark. For each run index below the run count it gates
// the run, seeds the state, drives the permutation core once per round,
// folds the lanes and XORs the sum into the checksum.
// Assumes: the core raises perm_done_i for one cycle per accepted request,
// and only after that request was accepted.
module perm_bench_ctrl
    import pbc_pkg::*;
#(
    parameter int LANES  = 25,
    parameter int LANE_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [CNT_W-1:0]         run_count_i,
    input  logic [CNT_W-1:0]         rounds_i,
    input  logic [CNT_W-1:0]         elem_count_i,
    input  logic [CNT_W-1:0]         freq_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [LANE_W-1:0]        checksum_o,
    output logic                     perm_req_o,
    input  logic                     perm_ready_i,
    output logic [LANES*LANE_W-1:0]  perm_state_o,
    input  logic                     perm_done_i,
    input  logic [LANES*LANE_W-1:0]  perm_state_i
);
    localparam int STATE_W = LANES * LANE_W;

    ctl_state_e         st_q;
    logic [CNT_W-1:0]   cfg_runs_q;
    logic [CNT_W-1:0]   cfg_rounds_q;
    logic [CNT_W-1:0]   cfg_elem_q;
    logic [CNT_W-1:0]   cfg_freq_q;
    logic [CNT_W-1:0]   run_idx_q;
    logic [CNT_W-1:0]   iter_q;
    logic [CNT_W-1:0]   iter_nxt;
    logic [STATE_W-1:0] state_q;
    logic [LANE_W-1:0]  csum_q;
    logic               run_active;
    logic [STATE_W-1:0] seed_state;
    logic [LANE_W-1:0]  lane_sum;

    pbc_run_gate #(.CNT_W(CNT_W)) u_gate (
        .run_idx_i  (run_idx_q),
        .elem_cnt_i (cfg_elem_q),
        .freq_i     (cfg_freq_q),
        .active_o   (run_active)
    );

    pbc_lane_seed #(.LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_seed (
        .run_idx_i (run_idx_q),
        .seed_o    (seed_state)
    );

    pbc_lane_fold #(.LANES(LANES), .LANE_W(LANE_W)) u_fold (
        .state_i (state_q),
        .sum_o   (lane_sum)
    );

    // Next iteration count, used to spot the last round.
    assign iter_nxt = iter_q + CNT_W'(1);

    // Controller FSM with configuration latch, counters, state and checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            cfg_runs_q   <= '0;
            cfg_rounds_q <= '0;
            cfg_elem_q   <= '0;
            cfg_freq_q   <= '0;
            run_idx_q    <= '0;
            iter_q       <= '0;
            state_q      <= '0;
            csum_q       <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_runs_q   <= run_count_i;
                        cfg_rounds_q <= rounds_i;
                        cfg_elem_q   <= elem_count_i;
                        cfg_freq_q   <= freq_i;
                        run_idx_q    <= '0;
                        csum_q       <= '0;
                        st_q         <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (run_idx_q >= cfg_runs_q) begin
                        st_q <= ST_FINISH;
                    end else if (run_active) begin
                        state_q <= seed_state;
                        iter_q  <= '0;
                        st_q    <= (cfg_rounds_q == '0) ? ST_FOLD : ST_ISSUE;
                    end else begin
                        run_idx_q <= run_idx_q + CNT_W'(1);
                    end
                end
                ST_ISSUE: begin
                    if (perm_ready_i) begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (perm_done_i) begin
                        state_q <= perm_state_i;
                        iter_q  <= iter_nxt;
                        st_q    <= (iter_nxt == cfg_rounds_q) ? ST_FOLD : ST_ISSUE;
                    end
                end
                ST_FOLD: begin
                    csum_q    <= csum_q ^ lane_sum;
                    run_idx_q <= run_idx_q + CNT_W'(1);
                    st_q      <= ST_EVAL;
                end
                ST_FINISH: begin
                    st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the controller state.
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = (st_q == ST_FINISH);
    assign perm_req_o   = (st_q == ST_ISSUE);
    assign perm_state_o = state_q;
    assign checksum_o   = csum_q;
endmodule

// File: rtl/pbc_checker.sv
// Module: pbc_checker
// Temporal properties of the controller, attached to the top through bind.
// Assumes: observes port-level signals only.
module pbc_checker #(
    parameter int STATE_W = 1600,
    parameter int LANE_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [LANE_W-1:0]  checksum_o,
    input logic               perm_req_o,
    input logic               perm_ready_i,
    input logic [STATE_W-1:0] perm_state_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                         // R7
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);                                         // R7
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !perm_req_o);                                    // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_req_o && !perm_ready_i) |=> (perm_req_o && $stable(perm_state_o))); // R8
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && checksum_o == '0));      // R6
    AST_CSUM_STEADY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        perm_req_o |=> $stable(checksum_o));                         // R5
endmodule

bind perm_bench_ctrl pbc_checker #(.STATE_W(LANES*LANE_W), .LANE_W(LANE_W)) u_pbc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .checksum_o   (checksum_o),
    .perm_req_o   (perm_req_o),
    .perm_ready_i (perm_ready_i),
    .perm_state_o (perm_state_o)
);

// File: tb/test_perm_bench_ctrl.sv
// Bench: directed scenarios, one task each, with a behavioural permutation core.
module test_perm_bench_ctrl;
    localparam int LN = 25;
    localparam int LW = 64;
    localparam int SW = LN * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [31:0]   run_count_i = '0;
    logic [31:0]   rounds_i = '0;
    logic [31:0]   elem_count_i = '0;
    logic [31:0]   freq_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [LW-1:0] checksum_o;
    logic          perm_req_o;
    logic          perm_ready_i = 1'b0;
    logic [SW-1:0] perm_state_o;
    logic          perm_done_i = 1'b0;
    logic [SW-1:0] perm_state_i = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int accepts = 0;
    int core_stall = 1;
    int core_lat = 2;
    bit finished = 1'b0;

    perm_bench_ctrl i_perm_bench_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .run_count_i(run_count_i), .rounds_i(rounds_i),
        .elem_count_i(elem_count_i), .freq_i(freq_i),
        .busy_o(busy_o), .done_o(done_o), .checksum_o(checksum_o),
        .perm_req_o(perm_req_o), .perm_ready_i(perm_ready_i),
        .perm_state_o(perm_state_o), .perm_done_i(perm_done_i),
        .perm_state_i(perm_state_i)
    );

    always #5 clk = ~clk;

    // Stand-in permutation: rotate lanes by one and add a lane-dependent constant.
    function automatic logic [SW-1:0] tb_perm(input logic [SW-1:0] s);
        logic [SW-1:0] r;
        for (int i = 0; i < LN; i++)
            r[i*LW +: LW] = s[((i + 1) % LN)*LW +: LW] + LW'(i + 1);
        return r;
    endfunction

    // Expected checksum computed directly from R1..R5.
    function automatic logic [LW-1:0] exp_csum(input int unsigned rc, input int unsigned rnd,
                                                input int unsigned el, input int unsigned fq);
        logic [LW-1:0] x = '0;
        logic [LW-1:0] sum;
        logic [SW-1:0] s;
        int unsigned f = (fq == 0) ? 1 : fq;
        for (int unsigned r = 0; r < rc; r++) begin
            if (el > (r % f)) begin
                for (int i = 0; i < LN; i++) s[i*LW +: LW] = LW'(i) + LW'(r);
                for (int unsigned k = 0; k < rnd; k++) s = tb_perm(s);
                sum = '0;
                for (int i = 0; i < LN; i++) sum = sum + s[i*LW +: LW];
                x = x ^ sum;
            end
        end
        return x;
    endfunction

    function automatic int exp_active(input int unsigned rc, input int unsigned el,
                                      input int unsigned fq);
        int n = 0;
        int unsigned f = (fq == 0) ? 1 : fq;
        for (int unsigned r = 0; r < rc; r++) if (el > (r % f)) n++;
        return n;
    endfunction

    // Behavioural core: stalls ready, then returns the result after a latency.
    initial begin
        int cst = 0;
        int cnt = 0;
        logic [SW-1:0] cap;
        forever begin
            @(negedge clk);
            case (cst)
                0: if (perm_req_o) begin cnt = 0; cst = 1; end
                1: if (cnt >= core_stall) begin perm_ready_i = 1'b1; cst = 2; end
                   else cnt++;
                2: begin
                    perm_ready_i = 1'b0; cap = tb_perm(perm_state_o);
                    accepts++; cnt = 0; cst = 3;
                end
                3: if (cnt >= core_lat) begin
                       perm_done_i = 1'b1; perm_state_i = cap; cst = 4;
                   end else cnt++;
                default: begin perm_done_i = 1'b0; cst = 0; end
            endcase
        end
    end

    task automatic check(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Launch a benchmark and wait at the negedge where done_o is high.
    task automatic run_job(input int unsigned rc, input int unsigned rnd,
                           input int unsigned el, input int unsigned fq);
        int g = 0;
        @(negedge clk);
        run_count_i = rc; rounds_i = rnd; elem_count_i = el; freq_i = fq;
        start_i = 1'b1; accepts = 0;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && g < 50000) begin @(negedge clk); g++; end
        check("R7 done reached", {63'd0, done_o}, 64'd1);
    endtask

    task automatic t_reset;
        check("R9 busy after reset", {63'd0, busy_o}, 64'd0);
        check("R9 done after reset", {63'd0, done_o}, 64'd0);
        check("R9 req after reset", {63'd0, perm_req_o}, 64'd0);
        check("R9 checksum after reset", checksum_o, 64'd0);
    endtask

    task automatic t_basic;
        run_job(4, 3, 10, 4);
        check("R3 R5 basic checksum", checksum_o, exp_csum(4, 3, 10, 4));
        check("R4 basic request count", 64'(accepts), 64'(exp_active(4, 10, 4) * 3));
        @(negedge clk);
        check("R7 done one cycle", {63'd0, done_o}, 64'd0);
        check("R7 busy low after done", {63'd0, busy_o}, 64'd0);
    endtask

    task automatic t_gating;
        run_job(12, 2, 2, 5);
        check("R1 gated checksum", checksum_o, exp_csum(12, 2, 2, 5));
        check("R1 gated request count", 64'(accepts), 64'(exp_active(12, 2, 5) * 2));
        run_job(6, 1, 3, 3);
        check("R1 boundary elem==freq all active", 64'(accepts), 64'd6);
        run_job(6, 1, 2, 3);
        check("R1 strict greater", 64'(accepts), 64'd4);
    endtask

    task automatic t_freq_zero;
        logic [LW-1:0] c0;
        run_job(5, 2, 1, 0);
        c0 = checksum_o;
        check("R2 freq zero checksum", c0, exp_csum(5, 2, 1, 1));
        run_job(5, 2, 1, 1);
        check("R2 freq zero equals freq one", checksum_o, c0);
        run_job(5, 2, 0, 0);
        check("R2 freq zero elem zero none active", checksum_o, 64'd0);
    endtask

    task automatic t_rounds_zero;
        run_job(3, 0, 7, 2);
        check("R4 zero rounds folds seed", checksum_o, exp_csum(3, 0, 7, 2));
        check("R4 zero rounds no requests", 64'(accepts), 64'd0);
    endtask

    task automatic t_run_zero;
        run_job(0, 4, 9, 1);
        check("R7 zero run count checksum", checksum_o, 64'd0);
    endtask

    task automatic t_start_busy;
        int g = 0;
        core_stall = 4;
        @(negedge clk);
        run_count_i = 3; rounds_i = 2; elem_count_i = 5; freq_i = 2;
        start_i = 1'b1; accepts = 0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        run_count_i = 9; rounds_i = 1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && g < 50000) begin @(negedge clk); g++; end
        check("R6 start while busy ignored", checksum_o, exp_csum(3, 2, 5, 2));
        check("R8 R4 stalled request count", 64'(accepts), 64'(exp_active(3, 5, 2) * 2));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 start on done cycle ignored busy", {63'd0, busy_o}, 64'd0);
        check("R6 start on done cycle keeps checksum", checksum_o, exp_csum(3, 2, 5, 2));
        core_stall = 1;
    endtask

    task automatic t_clear;
        run_job(2, 1, 1, 1);
        check("R6 nonzero before clear", {63'd0, checksum_o != 0}, 64'd1);
        run_job(4, 1, 0, 3);
        check("R6 checksum cleared on start", checksum_o, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gating();
        t_freq_zero();
        t_rounds_zero();
        t_run_zero();
        t_start_busy();
        t_clear();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule